// File: doc/BRIEF.md
# Banked Byte-Enabled Register File

This block stores the architectural registers of one execution cluster: 127 usable 64-bit registers. Storage is split four ways. The low address bit (the register's parity) picks the even or the odd group. Each group is then split into a lower and an upper 32-bit half. Each of the four resulting banks has two read lanes and one write port. Up to four write ports issue requests every cycle. A port writes either one 32-bit half or a full 64-bit register, under byte-granular enables. Because of the enables, byte and halfword updates need no prior read.

Reads are combinational. A read lane that hits a row being written in the same cycle sees the incoming bytes already merged in. This lets the file double as an operand forwarding path. The same module serves both the integer file and the floating-point file.

Top module: `banked_reg_file`

## Requirements
- R1: After reset every register reads as zero and `wrConflict` is low.
- R2: Read lanes 0 and 1 serve even registers and lanes 2 and 3 serve odd registers. A lane's `rdRow` value r selects register 2r for lanes 0–1 and register 2r+1 for lanes 2–3. The lane returns the upper half in bits 63:32.
- R3: A narrow write (`wrWide`=0) takes `wrData[31:0]` and enables `wrBe[3:0]`. It goes to the upper half when `wrHi`=1 and to the lower half otherwise, and is visible after the next rising clock edge.
- R4: A wide write (`wrWide`=1, `wrHi` ignored) sends `wrData[31:0]` under `wrBe[3:0]` to the lower half. It sends `wrData[63:32]` under `wrBe[7:4]` to the upper half of the same register.
- R5: Only bytes whose enable is 1 change. Bit i of an enable vector governs byte i of the word it covers.
- R6: In one cycle, four narrow writes to four distinct banks all complete, as do two wide writes of opposite parity. Neither case raises `wrConflict`.
- R7: When a lane reads a row whose bank is being written in the same cycle, the lane returns the new bytes for enabled positions and the stored bytes elsewhere.
- R8: The two lanes of a parity group read different registers independently in the same cycle.
- R9: Register 127 is unused: writes to it change nothing and never raise `wrConflict`, and reads of it (odd lane, row 63) return zero, including in a cycle that writes it.
- R10: When two valid writes target the same bank in one cycle, `wrConflict` is high in that cycle. The lowest-numbered port wins that bank; other banks still take their writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | NUM_WR | Write request per port |
| wrWide | input | NUM_WR | 1: 64-bit write, 0: 32-bit write |
| wrHi | input | NUM_WR | Half select for a 32-bit write |
| wrAddr | input | NUM_WR×7 | Destination register per port |
| wrData | input | NUM_WR×64 | Write data per port |
| wrBe | input | NUM_WR×8 | Byte enables per port |
| rdRow | input | 4×6 | Row per read lane (parity fixed by lane) |
| rdData | output | 4×64 | Read data per lane, bypassed |
| wrConflict | output | 1 | Two writes hit one bank this cycle |

## Verification
The hardest situation to reach from the ports is a read that coincides with a partial write to the same row. The bypass must merge new and stored bytes within one combinational path. To build it, the bench first loads a register with a known pattern. In a later cycle it drives a narrow write with a sparse enable and, at the same time, points a lane at that row. It samples the lane before the clock edge and checks the result again after the edge. Lost-conflict cases are reached by driving two ports, wide against narrow, at one bank. The bench then reads back which data survived.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int HALF_W = 32;
  localparam int BE_W   = HALF_W / 8;
  localparam int ADDR_W = 7;
  localparam int ROW_W  = ADDR_W - 1;
  localparam int ROWS   = 1 << ROW_W;
  localparam int BANKS  = 4;
  localparam int LANES  = 2;

  typedef struct packed {
    logic              en;
    logic [ROW_W-1:0]  row;
    logic [HALF_W-1:0] data;
    logic [BE_W-1:0]   be;
  } bankWr_t;
endpackage

// File: rtl/brf_wrCtrl.sv
module brf_wrCtrl
  import brf_pkg::*;
#(
  parameter int NUM_WR = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_WR-1:0]                wrEn,
  input  logic [NUM_WR-1:0]                wrWide,
  input  logic [NUM_WR-1:0]                wrHi,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]    wrAddr,
  input  logic [NUM_WR-1:0][2*HALF_W-1:0]  wrData,
  input  logic [NUM_WR-1:0][2*BE_W-1:0]    wrBe,
  output bankWr_t [BANKS-1:0]              bankWr,
  output logic                             wrConflict
);
  logic [NUM_WR-1:0] portValid;

  always_comb begin
    for (int p = 0; p < NUM_WR; p++)
      portValid[p] = wrEn[p] && (wrAddr[p] != {ADDR_W{1'b1}});
  end

  always_comb begin
    logic taken;
    logic req;
    bankWr     = '0;
    wrConflict = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      taken = 1'b0;
      for (int p = 0; p < NUM_WR; p++) begin
        req = portValid[p] && (wrAddr[p][0] == 1'(b / 2)) &&
              (wrWide[p] || (wrHi[p] == 1'(b % 2)));
        if (req) begin
          if (taken) begin
            wrConflict = 1'b1;
          end else begin
            taken          = 1'b1;
            bankWr[b].en   = 1'b1;
            bankWr[b].row  = wrAddr[p][ADDR_W-1:1];
            if (wrWide[p] && (b % 2 == 1)) begin
              bankWr[b].data = wrData[p][2*HALF_W-1:HALF_W];
              bankWr[b].be   = wrBe[p][2*BE_W-1:BE_W];
            end else begin
              bankWr[b].data = wrData[p][HALF_W-1:0];
              bankWr[b].be   = wrBe[p][BE_W-1:0];
            end
          end
        end
      end
    end
  end

  // R10
  conflict_needs_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrConflict |-> ($countones(portValid) >= 2));

  // R6
  disjoint_wide_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((portValid == NUM_WR'(3)) && (wrWide[1:0] == 2'b11) &&
     (wrAddr[0][0] != wrAddr[1][0])) |-> !wrConflict);

  // R9
  top_reg_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portValid == '0) |-> (!wrConflict && !bankWr[0].en && !bankWr[1].en &&
                           !bankWr[2].en && !bankWr[3].en));
endmodule

// File: rtl/brf_bank.sv
module brf_bank
  import brf_pkg::*;
#(
  parameter bit ZERO_TOP = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankWr_t                       wr,
  input  logic [LANES-1:0][ROW_W-1:0]   rdRow,
  output logic [LANES-1:0][HALF_W-1:0]  rdData
);
  logic [HALF_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr.en) begin
      for (int i = 0; i < BE_W; i++)
        if (wr.be[i]) mem[wr.row][8*i +: 8] <= wr.data[8*i +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rdData[k] = mem[rdRow[k]];
      if (wr.en && (wr.row == rdRow[k])) begin
        for (int i = 0; i < BE_W; i++)
          if (wr.be[i]) rdData[k][8*i +: 8] = wr.data[8*i +: 8];
      end
      if (ZERO_TOP && (rdRow[k] == ROW_W'(ROWS - 1))) rdData[k] = '0;
    end
  end

  // R7
  bypass_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wr.en && (wr.be == '1) && (wr.row == rdRow[0]) &&
     !(ZERO_TOP && (rdRow[0] == ROW_W'(ROWS - 1)))) |-> (rdData[0] == wr.data));

  // R3
  hold_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wr.en && (wr.be == '1)) && (rdRow[0] == $past(wr.row)) &&
     !(wr.en && (wr.row == rdRow[0]))) |-> (rdData[0] == $past(wr.data)));

  // R9
  zero_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ZERO_TOP && (rdRow[1] == ROW_W'(ROWS - 1))) |-> (rdData[1] == '0));
endmodule

// File: rtl/banked_reg_file.sv
module banked_reg_file
  import brf_pkg::*;
#(
  parameter int NUM_WR = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_WR-1:0]                wrEn,
  input  logic [NUM_WR-1:0]                wrWide,
  input  logic [NUM_WR-1:0]                wrHi,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]    wrAddr,
  input  logic [NUM_WR-1:0][2*HALF_W-1:0]  wrData,
  input  logic [NUM_WR-1:0][2*BE_W-1:0]    wrBe,
  input  logic [2*LANES-1:0][ROW_W-1:0]    rdRow,
  output logic [2*LANES-1:0][2*HALF_W-1:0] rdData,
  output logic                             wrConflict
);
  bankWr_t [BANKS-1:0] bankWr;
  logic [BANKS-1:0][LANES-1:0][HALF_W-1:0] bankRd;

  brf_wrCtrl #(.NUM_WR(NUM_WR)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWide(wrWide), .wrHi(wrHi),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .bankWr(bankWr), .wrConflict(wrConflict)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    localparam int PAR = g / 2;
    brf_bank #(.ZERO_TOP(PAR == 1)) u_bank (
      .clk(clk), .rstN(rstN), .wr(bankWr[g]),
      .rdRow(rdRow[PAR*LANES +: LANES]), .rdData(bankRd[g])
    );
  end

  for (genvar k = 0; k < 2*LANES; k++) begin : g_lane
    localparam int PAR = k / LANES;
    localparam int SUB = k % LANES;
    assign rdData[k] = {bankRd[PAR*2+1][SUB], bankRd[PAR*2][SUB]};
  end
endmodule

// File: tb/banked_reg_file_bench.sv
module banked_reg_file_bench;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NW-1:0] wrEn = '0, wrWide = '0, wrHi = '0;
  logic [NW-1:0][6:0]  wrAddr = '0;
  logic [NW-1:0][63:0] wrData = '0;
  logic [NW-1:0][7:0]  wrBe = '0;
  logic [3:0][5:0]  rdRow = '0;
  logic [3:0][63:0] rdData;
  logic wrConflict;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  banked_reg_file #(.NUM_WR(NW)) u_banked_reg_file (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWide(wrWide), .wrHi(wrHi),
    .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .rdRow(rdRow), .rdData(rdData), .wrConflict(wrConflict)
  );

  typedef struct packed {
    logic [6:0]  addr;
    logic        wide;
    logic        hi;
    logic [7:0]  be;
    logic [63:0] data;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{7'd4,   1'b1, 1'b0, 8'hFF, 64'h1122334455667788, 64'h1122334455667788},
    '{7'd4,   1'b0, 1'b0, 8'h01, 64'h00000000AABBCCDD, 64'h11223344556677DD},
    '{7'd4,   1'b0, 1'b1, 8'h08, 64'h0000000099000000, 64'h99223344556677DD},
    '{7'd7,   1'b1, 1'b0, 8'hF0, 64'hCAFEBABEDEADBEEF, 64'hCAFEBABE00000000},
    '{7'd7,   1'b0, 1'b0, 8'h03, 64'h0000000000001234, 64'hCAFEBABE00001234},
    '{7'd126, 1'b1, 1'b0, 8'hFF, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF},
    '{7'd127, 1'b1, 1'b0, 8'hFF, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000},
    '{7'd0,   1'b1, 1'b0, 8'h00, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000},
    '{7'd1,   1'b0, 1'b1, 8'h0F, 64'h000000005A5A5A5A, 64'h5A5A5A5A00000000},
    '{7'd6,   1'b1, 1'b0, 8'h3C, 64'hAABBCCDDEEFF0011, 64'h0000CCDDEEFF0000}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic setWr(input int p, input logic [6:0] a, input logic w, input logic h,
                       input logic [7:0] be, input logic [63:0] d);
    wrEn[p] = 1'b1; wrWide[p] = w; wrHi[p] = h;
    wrAddr[p] = a; wrBe[p] = be; wrData[p] = d;
  endtask

  task automatic clearWr();
    wrEn = '0; wrWide = '0; wrHi = '0; wrAddr = '0; wrBe = '0; wrData = '0;
  endtask

  // lane 0 for even, lane 2 for odd registers
  task automatic readReg(input logic [6:0] a, output logic [63:0] v);
    int lane;
    lane = a[0] ? 2 : 0;
    rdRow[lane] = a[6:1];
    #1;
    v = rdData[lane];
  endtask

  initial begin : watchdog
    #400000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(7'd4, v);   check("R1 reg4", v, 64'h0);
    readReg(7'd33, v);  check("R1 reg33", v, 64'h0);
    check("R1 conflict", {63'h0, wrConflict}, 64'h0);

    // table walk: R3 R4 R5 R9 R2
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      setWr(0, VECS[i].addr, VECS[i].wide, VECS[i].hi, VECS[i].be, VECS[i].data);
      #1;
      check($sformatf("R9 no conflict vec%0d", i), {63'h0, wrConflict}, 64'h0);
      @(negedge clk);
      clearWr();
      readReg(VECS[i].addr, v);
      check($sformatf("R3/R4/R5 vec%0d", i), v, VECS[i].exp);
    end

    // R6 four narrow writes to four banks
    @(negedge clk);
    setWr(0, 7'd10, 1'b0, 1'b0, 8'h0F, 64'h0000000010101010);
    setWr(1, 7'd10, 1'b0, 1'b1, 8'h0F, 64'h0000000020202020);
    setWr(2, 7'd11, 1'b0, 1'b0, 8'h0F, 64'h0000000030303030);
    setWr(3, 7'd11, 1'b0, 1'b1, 8'h0F, 64'h0000000040404040);
    #1; check("R6 four narrow no conflict", {63'h0, wrConflict}, 64'h0);
    @(negedge clk); clearWr();
    readReg(7'd10, v); check("R6 reg10", v, 64'h2020202010101010);
    readReg(7'd11, v); check("R6 reg11", v, 64'h4040404030303030);

    // R6 two wide writes of opposite parity
    @(negedge clk);
    setWr(0, 7'd20, 1'b1, 1'b0, 8'hFF, 64'h0A0B0C0D0E0F0102);
    setWr(1, 7'd21, 1'b1, 1'b0, 8'hFF, 64'h1112131415161718);
    #1; check("R6 two wide no conflict", {63'h0, wrConflict}, 64'h0);
    @(negedge clk); clearWr();
    readReg(7'd20, v); check("R6 reg20", v, 64'h0A0B0C0D0E0F0102);
    readReg(7'd21, v); check("R6 reg21", v, 64'h1112131415161718);

    // R7 bypass of a partial write (reg4 holds 99223344556677DD)
    @(negedge clk);
    setWr(0, 7'd4, 1'b0, 1'b0, 8'h03, 64'h000000000000BEEF);
    rdRow[0] = 6'd2;
    #2; check("R7 same-cycle bypass", rdData[0], 64'h992233445566BEEF);
    @(negedge clk); clearWr();
    #1; check("R7 stored after edge", rdData[0], 64'h992233445566BEEF);

    // R8 independent lanes
    rdRow[0] = 6'd2; rdRow[1] = 6'd3; rdRow[2] = 6'd3; rdRow[3] = 6'd0;
    #1;
    check("R8 lane0 reg4", rdData[0], 64'h992233445566BEEF);
    check("R8 lane1 reg6", rdData[1], 64'h0000CCDDEEFF0000);
    check("R8 lane2 reg7", rdData[2], 64'hCAFEBABE00001234);
    check("R8 lane3 reg1", rdData[3], 64'h5A5A5A5A00000000);

    // R9 read of reg127 while it is written
    @(negedge clk);
    setWr(0, 7'd127, 1'b1, 1'b0, 8'hFF, 64'hFFFFFFFFFFFFFFFF);
    rdRow[3] = 6'd63;
    #2; check("R9 reg127 bypass zero", rdData[3], 64'h0);
    @(negedge clk); clearWr();

    // R10 narrow vs narrow on one bank, port0 wins
    @(negedge clk);
    setWr(0, 7'd30, 1'b0, 1'b0, 8'h0F, 64'h00000000AAAAAAAA);
    setWr(2, 7'd30, 1'b0, 1'b0, 8'h0F, 64'h00000000BBBBBBBB);
    #1; check("R10 conflict flag", {63'h0, wrConflict}, 64'h1);
    @(negedge clk); clearWr();
    #1; check("R10 conflict clears", {63'h0, wrConflict}, 64'h0);
    readReg(7'd30, v); check("R10 low port wins", v, 64'h00000000AAAAAAAA);

    // R10 wide (port1) vs narrow hi (port3): port1 wins hi bank, lo taken
    @(negedge clk);
    setWr(1, 7'd31, 1'b1, 1'b0, 8'hFF, 64'h1111111122222222);
    setWr(3, 7'd31, 1'b0, 1'b1, 8'h0F, 64'h0000000033333333);
    #1; check("R10 wide conflict flag", {63'h0, wrConflict}, 64'h1);
    @(negedge clk); clearWr();
    readReg(7'd31, v); check("R10 wide wins", v, 64'h1111111122222222);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule